// File: doc/BRIEF.md
# Audio Sample Record/Playback Controller

This block captures one fixed-length clip of converter samples into an on-block single-port word memory and later streams the clip back out to a digital-to-analog converter. A record command starts a capture loop. In each step of that loop the controller strobes the analog-to-digital converter, places its value on the shared data path and writes it into the word at the current address. A play command starts a replay loop. In each step of that loop the controller reads the word at the current address and strobes the output converter one cycle later, when the read data has arrived.

Both loops share one address counter and one data path. The path is modelled as a multiplexer: it carries the converter sample while the input side drives it, and the memory read register at all other times. Each sample is narrower than a memory word and is stored zero-extended. A one-cycle done pulse marks the end of either loop.

Top module: `audio_rec_play`

## Requirements
- R1: While rst_ni is low, adc_load_o, adc_drive_o, dac_load_o and done_o are all 0.
- R2: A rec_i seen in idle at a rising edge gives exactly 4096 consecutive cycles with adc_load_o and adc_drive_o both 1, starting in the cycle after that edge. The two strobes are always equal.
- R3: Record step k (k = 0..4095) writes the adc_sample_i value of that cycle to word k, zero-extended from 12 to 16 bits (bits 15:12 = 0).
- R4: A play_i seen in idle at a rising edge gives exactly 4096 consecutive dac_load_o cycles, starting two cycles after that edge. On the k-th of them dac_sample_o equals word k.
- R5: adc_drive_o and adc_load_o stay 0 for the whole play loop, including its final dac_load_o cycle.
- R6: done_o is 1 for exactly one cycle per loop. After a record it comes in the cycle after the last adc_load_o. After a play it coincides with the last dac_load_o.
- R7: rec_i and play_i are ignored while a loop runs. The loop length, its data and its end cycle do not change.
- R8: If rec_i and play_i are both 1 in idle, a record loop starts and no play loop runs.
- R9: In idle with no command, all strobes, enables and done_o stay 0.
- R10: Every loop starts at address 0, so replaying a clip twice gives the same sample sequence both times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_i | input | 1 | Record command |
| play_i | input | 1 | Play command |
| adc_sample_i | input | 12 | Sample from the analog-to-digital converter |
| adc_load_o | output | 1 | Load strobe to the analog-to-digital converter |
| adc_drive_o | output | 1 | The converter sample drives the shared data path |
| dac_load_o | output | 1 | Load strobe to the digital-to-analog converter |
| dac_sample_o | output | 16 | Shared data path value presented to the output converter |
| done_o | output | 1 | One-cycle pulse at the end of a loop |

## Verification
Counting rising edges from the one that samples a command, record strobes cover cycles 1 to 4096 and record done falls in cycle 4097. Play strobes cover cycles 2 to 4097 because of the read register, and play done also falls in cycle 4097. The bench drives each command just after a falling edge. It then samples every output at each following falling edge and tags each sample with that cycle number, so the first, last and done cycles are compared with those exact values. Each converter sample is changed only at a falling edge of a cycle where adc_load_o is high, so the value written at the next rising edge is known, and the replayed words are compared with it one for one.

// File: rtl/arp_pkg.sv
package arp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_PLAY = 2'd2
  } arp_state_e;
endpackage

// File: rtl/arp_addr_cnt.sv
module arp_addr_cnt #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;
endmodule

// File: rtl/arp_spram.sv
module arp_spram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (en_i && !we_i)  rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/arp_seq_fsm.sv
module arp_seq_fsm
  import arp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rec_i,
  input  logic play_i,
  input  logic last_i,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic mem_en_o,
  output logic mem_we_o,
  output logic adc_load_o,
  output logic adc_drive_o,
  output logic dac_load_o,
  output logic done_o
);
  arp_state_e state_q, state_d;
  logic       dac_load_q, done_q;
  logic       in_loop;

  assign in_loop = (state_q != ST_IDLE);

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // record wins a tie
        if (rec_i) begin
          state_d   = ST_REC;
          cnt_clr_o = 1'b1;
        end else if (play_i) begin
          state_d   = ST_PLAY;
          cnt_clr_o = 1'b1;
        end
      end
      ST_REC, ST_PLAY: begin
        if (last_i) state_d   = ST_IDLE;
        else        cnt_inc_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      dac_load_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      // read data lands one cycle after the read step
      dac_load_q <= (state_q == ST_PLAY);
      done_q     <= in_loop && last_i;
    end
  end

  assign mem_en_o    = in_loop;
  assign mem_we_o    = (state_q == ST_REC);
  assign adc_load_o  = (state_q == ST_REC);
  assign adc_drive_o = (state_q == ST_REC);
  assign dac_load_o  = dac_load_q;
  assign done_o      = done_q;
endmodule

// File: rtl/audio_rec_play.sv
module audio_rec_play #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rec_i,
  input  logic                play_i,
  input  logic [SAMPLE_W-1:0] adc_sample_i,
  output logic                adc_load_o,
  output logic                adc_drive_o,
  output logic                dac_load_o,
  output logic [DATA_W-1:0]   dac_sample_o,
  output logic                done_o
);
  localparam int PAD_W = DATA_W - SAMPLE_W;

  logic              cnt_clr, cnt_inc, last;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] rd_data, adc_word, bus_w;

  arp_seq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rec_i       (rec_i),
    .play_i      (play_i),
    .last_i      (last),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .mem_en_o    (mem_en),
    .mem_we_o    (mem_we),
    .adc_load_o  (adc_load_o),
    .adc_drive_o (adc_drive_o),
    .dac_load_o  (dac_load_o),
    .done_o      (done_o)
  );

  arp_addr_cnt #(.ADDR_W(ADDR_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .addr_o (mem_addr),
    .last_o (last)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign adc_word = {{PAD_W{1'b0}}, adc_sample_i};
    end else begin : g_nopad
      assign adc_word = adc_sample_i[DATA_W-1:0];
    end
  endgenerate

  // shared data path: converter drives it, otherwise memory read register
  assign bus_w        = adc_drive_o ? adc_word : rd_data;
  assign dac_sample_o = bus_w;

  arp_spram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (bus_w),
    .rdata_o (rd_data)
  );
endmodule

// File: rtl/arp_checker.sv
module arp_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_load_o,
  input logic              adc_drive_o,
  input logic              dac_load_o,
  input logic              done_o,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_LOAD_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_load_o |-> (mem_we && mem_en)); // R2
  AST_WRITE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> adc_drive_o); // R3
  AST_DAC_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_load_o |-> $past(mem_en && !mem_we)); // R4
  AST_NO_DRIVE_IN_PLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_load_o |-> !adc_drive_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_en) && ($past(mem_addr) == '1))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en && $past(mem_en)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R2
  AST_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_en) |-> (mem_addr == '0)); // R10
endmodule

bind audio_rec_play arp_checker #(.ADDR_W(ADDR_W)) i_arp_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .adc_load_o  (adc_load_o),
  .adc_drive_o (adc_drive_o),
  .dac_load_o  (dac_load_o),
  .done_o      (done_o),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr)
);

// File: tb/test_audio_rec_play.sv
module test_audio_rec_play;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 16;
  localparam int SAMPLE_W = 12;
  localparam int DEPTH    = 1 << ADDR_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rec_i = 1'b0;
  logic play_i = 1'b0;
  logic [SAMPLE_W-1:0] adc_sample_i = '0;
  logic adc_load_o, adc_drive_o, dac_load_o, done_o;
  logic [DATA_W-1:0] dac_sample_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] exp_mem [DEPTH];

  always #2 clk_i = ~clk_i;

  audio_rec_play #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)) i_audio_rec_play (
    .clk_i, .rst_ni, .rec_i, .play_i, .adc_sample_i,
    .adc_load_o, .adc_drive_o, .dac_load_o, .dac_sample_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [SAMPLE_W-1:0] smp(input int k, input int seed);
    return SAMPLE_W'(((k * 29) + (seed * 131)) ^ (k >> 2));
  endfunction

  // command issued before rising edge 0; cycle c is sampled at the c-th falling edge after it
  task automatic run_loop(input bit r, input bit p, input int seed, input int g,
                          input bit gr, input bit gp, input bit exp_rec, input string tag);
    int first_adc, last_adc, first_dac, last_dac;
    int n_adc, n_dac, n_done, c_done, drive_err, data_err;
    longint bad_act, bad_exp;
    first_adc = -1; last_adc = -1; first_dac = -1; last_dac = -1;
    n_adc = 0; n_dac = 0; n_done = 0; c_done = -1; drive_err = 0; data_err = 0;
    bad_act = 0; bad_exp = 0;
    @(negedge clk_i);
    rec_i  = r;
    play_i = p;
    for (int c = 1; c <= 4100; c++) begin
      @(negedge clk_i);
      rec_i  = (c == g) ? gr : 1'b0;
      play_i = (c == g) ? gp : 1'b0;
      if (adc_drive_o !== adc_load_o) drive_err++;
      if (adc_load_o === 1'b1) begin
        if (first_adc < 0) first_adc = c;
        last_adc = c;
        adc_sample_i = smp(n_adc, seed);
        if (exp_rec && n_adc < DEPTH) exp_mem[n_adc] = DATA_W'(smp(n_adc, seed));
        n_adc++;
      end
      if (dac_load_o === 1'b1) begin
        if (first_dac < 0) first_dac = c;
        last_dac = c;
        if (n_dac < DEPTH && dac_sample_o !== exp_mem[n_dac]) begin
          if (data_err == 0) begin
            bad_act = longint'(dac_sample_o);
            bad_exp = longint'(exp_mem[n_dac]);
          end
          data_err++;
        end
        n_dac++;
      end
      if (done_o === 1'b1) begin
        n_done++;
        c_done = c;
      end
    end
    chk(drive_err == 0, "R2", {tag, " drive equals load"}, drive_err, 0);
    chk(n_done == 1, "R6", {tag, " done pulse count"}, n_done, 1);
    chk(c_done == 4097, "R6", {tag, " done cycle"}, c_done, 4097);
    if (exp_rec) begin
      chk(n_adc == DEPTH, "R2", {tag, " record step count"}, n_adc, DEPTH);
      chk(first_adc == 1 && last_adc == 4096, "R2", {tag, " record window last"}, last_adc, 4096);
      chk(first_adc == 1, "R2", {tag, " record window first"}, first_adc, 1);
      chk(n_dac == 0, "R8", {tag, " no play strobes"}, n_dac, 0);
    end else begin
      chk(n_dac == DEPTH, "R4", {tag, " play step count"}, n_dac, DEPTH);
      chk(first_dac == 2, "R4", {tag, " play window first"}, first_dac, 2);
      chk(last_dac == 4097, "R4", {tag, " play window last"}, last_dac, 4097);
      chk(data_err == 0, "R3", {tag, " replayed word"}, bad_act, bad_exp);
      chk(n_adc == 0, "R5", {tag, " no converter drive in play"}, n_adc, 0);
    end
  endtask

  initial begin
    int quiet_err;
    repeat (3) @(negedge clk_i);
    chk(adc_load_o === 1'b0 && adc_drive_o === 1'b0, "R1", "adc strobes in reset",
        {adc_load_o, adc_drive_o}, 0);
    chk(dac_load_o === 1'b0 && done_o === 1'b0, "R1", "dac load and done in reset",
        {dac_load_o, done_o}, 0);
    rst_ni = 1'b1;
    quiet_err = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if ({adc_load_o, adc_drive_o, dac_load_o, done_o} !== 4'b0) quiet_err++;
    end
    chk(quiet_err == 0, "R9", "idle outputs quiet", quiet_err, 0);

    run_loop(1'b1, 1'b0, 3, 0, 1'b0, 1'b0, 1'b1, "rec seed3");
    run_loop(1'b0, 1'b1, 3, 0, 1'b0, 1'b0, 1'b0, "play seed3");
    run_loop(1'b0, 1'b1, 3, 0, 1'b0, 1'b0, 1'b0, "R10 replay seed3");
    // R7: commands during a running record loop
    run_loop(1'b1, 1'b0, 9, 100, 1'b1, 1'b1, 1'b1, "R7 rec with stray cmds");
    // R7: record command during a running play loop
    run_loop(1'b0, 1'b1, 9, 2000, 1'b1, 1'b0, 1'b0, "R7 play with stray rec");
    // R8: both commands at once
    run_loop(1'b1, 1'b1, 17, 0, 1'b0, 1'b0, 1'b1, "R8 both cmds");
    run_loop(1'b0, 1'b1, 17, 0, 1'b0, 1'b0, 1'b0, "R8 play after tie");

    quiet_err = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if ({adc_load_o, adc_drive_o, dac_load_o, done_o} !== 4'b0) quiet_err++;
    end
    chk(quiet_err == 0, "R9", "idle quiet after loops", quiet_err, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule